// File: doc/BRIEF.md
# Smart Card Cold-Reset Sequencer

This block runs the cold-reset activation of a smart card or SIM contact interface. A start request, given once supply power is good, switches on the card clock. That instant is the first time reference. A fixed number of card clock cycles later the block raises the I/O line to its asserted level. It then watches a receive line for the card's first response, which is a falling edge, and checks that the edge falls inside a minimum-to-maximum window counted in card clock cycles.

Two card styles are supported, chosen by a mode input that is latched at start. A self-resetting card has its response window counted from clock enable, and its reset pin stays low. For a card with an active-low reset pin, the block first holds reset low for a fixed number of card cycles and ignores the receive line during that time. It then drives reset high, and that edge becomes the second time reference for the response window. A response in the window moves the block to an active state that lasts until a deactivate request. An early edge or a missing response ends the attempt with an error flag, and the contacts return to their inactive levels.

All windows count ticks of a card-clock strobe. The strobe is produced internally once every DIV_RATIO system clocks, starting with the start request. The receive line passes through a two-flop synchronizer before edge detection.

Top module: `card_rst_seq`

## Requirements
- R1: After reset, clk_en_o, data_o, rst_pin_o, answer_o, timeout_o and early_o are all 0.
- R2: When start_i is high in the idle state, clk_en_o is 1 from the next clock edge. mode_i is sampled at that edge (0 = self-resetting card, 1 = card with active-low reset pin). The start also clears timeout_o and early_o.
- R3: data_o rises exactly DATA_TICKS*DIV_RATIO system clocks after clk_en_o rises. DATA_TICKS must be smaller than WIN_MIN.
- R4: In mode 0, rst_pin_o stays 0. A falling edge on rx_i at a count of at least WIN_MIN card ticks after clk_en_o rose sets answer_o, and answer_o stays 1 with the clock and data held until deact_i.
- R5: A falling edge on rx_i that is fewer than WIN_MIN ticks after the current reference sets early_o and returns clk_en_o, data_o and rst_pin_o to 0.
- R6: If no falling edge has arrived when WIN_MAX+1 ticks have elapsed since the current reference, timeout_o rises exactly (WIN_MAX+1)*DIV_RATIO system clocks after that reference. At the same moment clk_en_o, data_o and rst_pin_o return to 0.
- R7: In mode 1, rst_pin_o rises exactly LOW_TICKS*DIV_RATIO system clocks after clk_en_o rises. That rise is the reference for the response window.
- R8: In mode 1, edges on rx_i during the low-reset phase set no flag and do not change the timing of the reset release.
- R9: In mode 1, a falling edge at WIN_MIN or more ticks after the reset release sets answer_o, and rst_pin_o stays 1 while active.
- R10: deact_i in any non-idle state returns every contact output and answer_o to 0. The error flags keep their value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Activation request (power good) |
| deact_i | input | 1 | Deactivation request |
| mode_i | input | 1 | Card style: 0 self-resetting, 1 active-low reset pin |
| rx_i | input | 1 | Receive line from the card, asynchronous |
| clk_en_o | output | 1 | Card clock enable |
| data_o | output | 1 | I/O line asserted level |
| rst_pin_o | output | 1 | Card reset pin level |
| answer_o | output | 1 | Valid response seen, interface active |
| timeout_o | output | 1 | No response within the window |
| early_o | output | 1 | Response came before the window minimum |

## Verification
The hardest situation to reach from the ports is a receive-line edge in mode 1 that lands inside the low-reset phase. Because it is ignored, nothing at the outputs reveals whether it was seen. The bench pulses rx_i in the middle of that phase and then measures the exact cycle at which the reset pin rises, expecting no shift. It then checks that the flags are still clear. Window edges are reached by counting system clocks from the observed clock-enable or reset rise, using a small tick ratio and small windows.

// File: rtl/crs_pkg.sv
// Package: shared types of the card reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package crs_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,  // contacts inactive
        SQ_PHASE_A = 2'd1,  // clock running, counting from clock enable
        SQ_PHASE_B = 2'd2,  // reset released, counting from reset rise
        SQ_ACTIVE  = 2'd3   // valid response received
    } seq_state_t;
endpackage

// File: rtl/crs_tick_gen.sv
// Module: card clock tick strobe. It pulses once every DIV ticks of the
// system clock while run_i is high and restarts from zero whenever
// run_i is low.
// Assumes: DIV >= 2.
module crs_tick_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    // Purpose: divide the system clock down to card clock ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)  div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    assign tick_o = run_i && (div_q == LAST);
endmodule

// File: rtl/crs_rx_edge.sv
// Module: two-flop synchronizer for the card receive line, followed by a
// falling-edge detector.
// Assumes: the line idles high, so reset values are 1.
module crs_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic fall_o
);
    logic meta_q, sync_q, prev_q;

    // Purpose: resynchronize rx_i and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= rx_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign fall_o = prev_q && !sync_q;
endmodule

// File: rtl/crs_ref_counter.sv
// Module: card-cycle counter relative to the current time reference.
// Clear has priority; otherwise the counter advances on each tick.
// Assumes: the controller leaves each phase before the counter wraps.
module crs_ref_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         tick_i,
    output logic [W-1:0] count_o
);
    // Purpose: count card ticks since the last reference.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) count_o <= '0;
        else if (tick_i)       count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/card_rst_seq.sv
// Module: top of the smart card cold-reset sequencer. It runs the
// activation phases for self-resetting cards and for cards with an
// active-low reset pin, and classifies the first response as valid,
// early or missing.
// Assumes: DATA_TICKS < WIN_MIN <= WIN_MAX, and LOW_TICKS >= 1.
module card_rst_seq #(
    parameter int DIV_RATIO  = 8,
    parameter int DATA_TICKS = 200,
    parameter int WIN_MIN    = 400,
    parameter int WIN_MAX    = 40000,
    parameter int LOW_TICKS  = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic deact_i,
    input  logic mode_i,
    input  logic rx_i,
    output logic clk_en_o,
    output logic data_o,
    output logic rst_pin_o,
    output logic answer_o,
    output logic timeout_o,
    output logic early_o
);
    import crs_pkg::*;

    localparam int TOP = (WIN_MAX > LOW_TICKS) ? WIN_MAX : LOW_TICKS;
    localparam int CW  = $clog2(TOP + 2);
    localparam logic [CW-1:0] DATA_C = CW'(DATA_TICKS);
    localparam logic [CW-1:0] MIN_C  = CW'(WIN_MIN);
    localparam logic [CW-1:0] MAX_C  = CW'(WIN_MAX);
    localparam logic [CW-1:0] LOW_C  = CW'(LOW_TICKS - 1);

    seq_state_t    state_q, state_d;
    logic          mode_q;
    logic          tick, fall, cnt_clear, release_rst;
    logic          set_early, set_tout;
    logic [CW-1:0] cnt;

    crs_tick_gen #(.DIV(DIV_RATIO)) u_tick (
        .clk(clk), .rst_n(rst_n), .run_i(state_q != SQ_IDLE), .tick_o(tick)
    );

    crs_rx_edge u_rx (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .fall_o(fall)
    );

    crs_ref_counter #(.W(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear_i(cnt_clear), .tick_i(tick), .count_o(cnt)
    );

    assign release_rst = (state_q == SQ_PHASE_A) && mode_q && tick && (cnt == LOW_C);
    assign cnt_clear   = (state_q == SQ_IDLE) || release_rst;

    // Purpose: choose the next phase and the error outcome of this cycle.
    always_comb begin
        state_d   = state_q;
        set_early = 1'b0;
        set_tout  = 1'b0;
        unique case (state_q)
            SQ_IDLE: if (start_i) state_d = SQ_PHASE_A;
            SQ_PHASE_A, SQ_PHASE_B: begin
                if (deact_i) begin
                    state_d = SQ_IDLE;
                end else if (state_q == SQ_PHASE_A && mode_q) begin
                    if (release_rst) state_d = SQ_PHASE_B;
                end else if (fall) begin
                    if (cnt < MIN_C) begin
                        set_early = 1'b1;
                        state_d   = SQ_IDLE;
                    end else begin
                        state_d = SQ_ACTIVE;
                    end
                end else if (tick && cnt == MAX_C) begin
                    set_tout = 1'b1;
                    state_d  = SQ_IDLE;
                end
            end
            SQ_ACTIVE: if (deact_i) state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    // Purpose: hold the phase register and the latched card style.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == SQ_IDLE && start_i) mode_q <= mode_i;
        end
    end

    // Purpose: sticky error flags, cleared by a new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_o <= 1'b0;
            early_o   <= 1'b0;
        end else if (state_q == SQ_IDLE && start_i) begin
            timeout_o <= 1'b0;
            early_o   <= 1'b0;
        end else begin
            if (set_tout)  timeout_o <= 1'b1;
            if (set_early) early_o   <= 1'b1;
        end
    end

    // Purpose: decode the contact levels from the phase.
    always_comb begin
        clk_en_o  = (state_q != SQ_IDLE);
        answer_o  = (state_q == SQ_ACTIVE);
        rst_pin_o = (state_q == SQ_PHASE_B) || (state_q == SQ_ACTIVE && mode_q);
        data_o    = (state_q == SQ_PHASE_B) || (state_q == SQ_ACTIVE) ||
                    (state_q == SQ_PHASE_A && cnt >= DATA_C);
    end
endmodule

// File: rtl/crs_chk.sv
// Module: assertion checker for card_rst_seq, attached by bind.
// Assumes: the same parameter values as the bound instance.
module crs_chk #(
    parameter int DIV_RATIO  = 8,
    parameter int DATA_TICKS = 200,
    parameter int LOW_TICKS  = 40000
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic deact_i,
    input logic mode_i,
    input logic clk_en_o,
    input logic data_o,
    input logic rst_pin_o,
    input logic answer_o,
    input logic timeout_o,
    input logic early_o
);
    logic [31:0] cyc_q;
    logic        mode_seen_q;

    // Purpose: count system clocks since the clock enable rose.
    always_ff @(posedge clk) begin
        if (!rst_n || !clk_en_o) cyc_q <= '0;
        else                     cyc_q <= cyc_q + 1'b1;
    end

    // Purpose: remember the card style sampled at start.
    always_ff @(posedge clk) begin
        if (!rst_n)                    mode_seen_q <= 1'b0;
        else if (!clk_en_o && start_i) mode_seen_q <= mode_i;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en_o |-> (!data_o && !rst_pin_o && !answer_o));

    p_enable_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en_o) |-> $past(start_i));

    p_data_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_o) |-> (cyc_q == 32'(DATA_TICKS * DIV_RATIO)));

    p_no_rst_mode0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_o && !mode_seen_q) |-> !rst_pin_o);

    p_answer_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (answer_o && !deact_i) |=> answer_o);

    p_early_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(early_o) |-> !clk_en_o);

    p_timeout_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> (!clk_en_o && !answer_o));

    p_release_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pin_o) |-> (cyc_q == 32'(LOW_TICKS * DIV_RATIO)));

    p_outcome_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({answer_o, timeout_o, early_o}));

    p_deact_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_o && deact_i) |=> !clk_en_o);
endmodule

bind card_rst_seq crs_chk #(
    .DIV_RATIO(DIV_RATIO), .DATA_TICKS(DATA_TICKS), .LOW_TICKS(LOW_TICKS)
) u_crs_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .deact_i(deact_i),
    .mode_i(mode_i), .clk_en_o(clk_en_o), .data_o(data_o),
    .rst_pin_o(rst_pin_o), .answer_o(answer_o), .timeout_o(timeout_o),
    .early_o(early_o)
);

// File: tb/tb_card_rst_seq.sv
// Bench: directed scenarios for card_rst_seq, one task each.
module tb_card_rst_seq;
    localparam int DIV  = 4;
    localparam int DATA = 10;
    localparam int WMIN = 20;
    localparam int WMAX = 200;
    localparam int LOW  = 200;
    localparam int LIM  = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, deact_i = 1'b0, mode_i = 1'b0, rx_i = 1'b1;
    logic clk_en_o, data_o, rst_pin_o, answer_o, timeout_o, early_o;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    card_rst_seq #(
        .DIV_RATIO(DIV), .DATA_TICKS(DATA), .WIN_MIN(WMIN),
        .WIN_MAX(WMAX), .LOW_TICKS(LOW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .deact_i(deact_i),
        .mode_i(mode_i), .rx_i(rx_i), .clk_en_o(clk_en_o), .data_o(data_o),
        .rst_pin_o(rst_pin_o), .answer_o(answer_o), .timeout_o(timeout_o),
        .early_o(early_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Pulse start; on return clk_en_o has just risen (cycle index 0).
    task automatic do_start(input logic m);
        @(negedge clk);
        start_i = 1'b1;
        mode_i  = m;
        @(negedge clk);
        start_i = 1'b0;
        mode_i  = 1'b0;
    endtask

    task automatic do_deact();
        deact_i = 1'b1;
        @(negedge clk);
        deact_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(!clk_en_o && !data_o && !rst_pin_o, "R1", "contacts after reset",
            {clk_en_o, data_o, rst_pin_o}, 0);
        chk(!answer_o && !timeout_o && !early_o, "R1", "flags after reset",
            {answer_o, timeout_o, early_o}, 0);
    endtask

    task automatic t_mode0_answer();
        int cyc;
        do_start(1'b0);
        chk(clk_en_o == 1'b1, "R2", "clock enable after start", clk_en_o, 1);
        cyc = 0;
        while (!data_o && cyc < LIM) begin @(negedge clk); cyc++; end
        chk(cyc == DATA * DIV, "R3", "data assert delay", cyc, DATA * DIV);
        idle_cycles((WMIN - DATA) * DIV + 20);
        rx_i = 1'b0;
        idle_cycles(5);
        chk(answer_o == 1'b1, "R4", "answer in window", answer_o, 1);
        chk(rst_pin_o == 1'b0, "R4", "reset pin low in mode 0", rst_pin_o, 0);
        rx_i = 1'b1;
        idle_cycles(WMAX * DIV);
        chk(answer_o && clk_en_o && data_o, "R4", "active held",
            {answer_o, clk_en_o, data_o}, 7);
        do_deact();
        chk(!answer_o && !clk_en_o && !data_o, "R10", "deactivate drops all",
            {answer_o, clk_en_o, data_o}, 0);
        idle_cycles(5);
    endtask

    task automatic t_mode0_early();
        do_start(1'b0);
        idle_cycles(5 * DIV);
        rx_i = 1'b0;
        idle_cycles(5);
        chk(early_o == 1'b1, "R5", "early flag", early_o, 1);
        chk(!clk_en_o && !data_o, "R5", "contacts dropped on early",
            {clk_en_o, data_o}, 0);
        rx_i = 1'b1;
        idle_cycles(20);
        chk(early_o == 1'b1, "R10", "early flag kept in idle", early_o, 1);
    endtask

    task automatic t_mode0_timeout();
        int cyc;
        do_start(1'b0);
        chk(early_o == 1'b0, "R2", "start clears early flag", early_o, 0);
        cyc = 0;
        while (!timeout_o && cyc < LIM) begin @(negedge clk); cyc++; end
        chk(cyc == (WMAX + 1) * DIV, "R6", "timeout delay from enable", cyc, (WMAX + 1) * DIV);
        chk(!clk_en_o && !data_o && !rst_pin_o, "R6", "contacts dropped on timeout",
            {clk_en_o, data_o, rst_pin_o}, 0);
        idle_cycles(5);
    endtask

    task automatic t_mode1_answer();
        int cyc;
        do_start(1'b1);
        chk(timeout_o == 1'b0, "R2", "start clears timeout flag", timeout_o, 0);
        cyc = 0;
        while (cyc < (LOW / 2) * DIV) begin @(negedge clk); cyc++; end
        rx_i = 1'b0;
        idle_cycles(8); cyc += 8;
        rx_i = 1'b1;
        idle_cycles(8); cyc += 8;
        chk(!answer_o && !early_o && !timeout_o && clk_en_o && !rst_pin_o, "R8",
            "edge in low phase ignored",
            {answer_o, early_o, timeout_o, clk_en_o, rst_pin_o}, 4'b0010);
        while (!rst_pin_o && cyc < LIM) begin @(negedge clk); cyc++; end
        chk(cyc == LOW * DIV, "R7", "reset release delay", cyc, LOW * DIV);
        chk(!early_o && !answer_o, "R8", "no flag after release",
            {early_o, answer_o}, 0);
        idle_cycles(WMIN * DIV + 20);
        rx_i = 1'b0;
        idle_cycles(5);
        chk(answer_o == 1'b1, "R9", "answer after release", answer_o, 1);
        chk(rst_pin_o == 1'b1, "R9", "reset pin high while active", rst_pin_o, 1);
        rx_i = 1'b1;
        idle_cycles(10);
        do_deact();
        chk(!rst_pin_o && !clk_en_o && !answer_o, "R10", "deactivate from mode 1",
            {rst_pin_o, clk_en_o, answer_o}, 0);
        idle_cycles(5);
    endtask

    task automatic t_mode1_early_and_timeout();
        int cyc;
        do_start(1'b1);
        cyc = 0;
        while (!rst_pin_o && cyc < LIM) begin @(negedge clk); cyc++; end
        idle_cycles(5 * DIV);
        rx_i = 1'b0;
        idle_cycles(5);
        chk(early_o == 1'b1 && !rst_pin_o, "R5", "early after release",
            {early_o, rst_pin_o}, 2);
        rx_i = 1'b1;
        idle_cycles(10);
        do_start(1'b1);
        cyc = 0;
        while (!rst_pin_o && cyc < LIM) begin @(negedge clk); cyc++; end
        cyc = 0;
        while (!timeout_o && cyc < LIM) begin @(negedge clk); cyc++; end
        chk(cyc == (WMAX + 1) * DIV, "R6", "timeout delay from release", cyc, (WMAX + 1) * DIV);
        chk(!rst_pin_o && !clk_en_o, "R6", "contacts dropped mode 1",
            {rst_pin_o, clk_en_o}, 0);
        idle_cycles(5);
    endtask

    task automatic t_abort_phase();
        do_start(1'b1);
        idle_cycles(30);
        do_deact();
        chk(!clk_en_o && !data_o && !rst_pin_o, "R10", "deactivate in low phase",
            {clk_en_o, data_o, rst_pin_o}, 0);
        idle_cycles(LOW * DIV);
        chk(!clk_en_o && !rst_pin_o, "R10", "stays idle after abort",
            {clk_en_o, rst_pin_o}, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle_cycles(4);
        rst_n = 1'b1;
        idle_cycles(2);
        t_reset();
        t_mode0_answer();
        t_mode0_early();
        t_mode0_timeout();
        t_mode1_answer();
        t_mode1_early_and_timeout();
        t_abort_phase();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule